// File: doc/BRIEF.md
# Translation Lookaside Buffer with Recency-Bit Replacement

This block is a small fully associative translation cache. It maps virtual page numbers onto physical frame numbers for fixed 4 KiB pages and keeps three permission flags with every mapping. A lookup presents a virtual address and an access kind. One cycle later it returns either a hit carrying the physical address, a miss, or a permission fault. After the page walker resolves a miss, it installs the result through a fill port. Software can invalidate one translation through a flush port.

Each entry carries one recency bit, and the replacement choice comes from these bits. A tag match sets the bit of the matched entry. Once the buffer is full, a match also clears every other bit. A fill that takes the last free slot clears all bits first. When the buffer is already full, a fill evicts the lowest-indexed entry whose bit is clear. Three free-running counters record hits, misses and evictions. The lookup, fill and flush ports are used one at a time: at most one of the three valid strobes is high in any cycle.

Top module: `tlb_mru`

## Requirements
- R1: `res_valid` is high in exactly the cycle after a cycle in which `lk_valid` was high, and low otherwise.
- R2: On a hit (`res_status` = 01), `res_paddr` is the stored frame number placed above the 12 low virtual-address bits, which pass through unchanged.
- R3: Permission flags are packed as bit 0 = read, bit 1 = write, bit 2 = execute. Access kind 00 (fetch) needs read and execute, 01 (load) needs read, 10 (store) needs write, and 11 is treated as a load. A matched entry that lacks a needed flag returns `res_status` = 10. An unmatched lookup returns 00. In both of these cases `res_paddr` is zero.
- R4: Any tag match, faulting or not, sets the matched entry's recency bit. If every entry is valid at that moment, all other recency bits are cleared.
- R5: A fill with a new page number writes into the lowest-indexed free slot with its recency bit clear. If exactly one slot was free before the fill, all recency bits are cleared first.
- R6: A fill with a new page number into a full buffer replaces the lowest-indexed entry whose recency bit is clear, and increments `cnt_evict` by one.
- R7: A fill whose page number is already present overwrites that entry's frame number and flags in place. It evicts nothing and leaves the recency bits unchanged.
- R8: A flush removes the entry with the given page number. A flush that matches no entry changes nothing.
- R9: Every lookup increments exactly one counter: `cnt_hit` when a tag matched (including faults), `cnt_miss` otherwise. Fills and flushes touch neither counter.
- R10: After reset, all entries are invalid, all counters are zero and `res_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | Lookup request strobe |
| lk_vaddr | input | VA_W | Virtual address to translate |
| lk_kind | input | 2 | Access kind: 00 fetch, 01 load, 10 store, 11 load |
| fill_valid | input | 1 | Install strobe |
| fill_vpn | input | VA_W-12 | Page number to install |
| fill_pfn | input | PA_W-12 | Frame number to install |
| fill_perm | input | 3 | Flags {execute, write, read} |
| flush_valid | input | 1 | Invalidate strobe |
| flush_vpn | input | VA_W-12 | Page number to invalidate |
| res_valid | output | 1 | Lookup result valid |
| res_status | output | 2 | 00 miss, 01 hit, 10 fault |
| res_paddr | output | PA_W | Physical address on a hit, else zero |
| cnt_hit | output | CNT_W | Lookups that matched a tag |
| cnt_miss | output | CNT_W | Lookups that matched nothing |
| cnt_evict | output | CNT_W | Fills that displaced a valid entry |

## Verification
Corrupted recency bits cannot be seen directly. They surface only at the next fill into a full buffer, when the wrong entry is displaced. The displaced page then misses on its next lookup, and the page that should have gone keeps hitting, so the fault may appear many operations after the damage. A wrong tag or flag shows up at the very next lookup of that page, as a wrong status or address one cycle after the request. The bench runs a behavioural model of the buffer alongside the design. It checks every lookup and every counter value after each operation, so a divergence is reported at the first lookup that exposes it.

// File: rtl/tlb_pkg.sv
// Shared encodings for the translation buffer.
package tlb_pkg;
    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_LOAD  = 2'd1,
        ACC_STORE = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    typedef enum logic [1:0] {
        RES_MISS  = 2'd0,
        RES_HIT   = 2'd1,
        RES_FAULT = 2'd2
    } res_e;

    // Read flag in bit 0, write in bit 1, execute in bit 2.
    typedef struct packed {
        logic x;
        logic w;
        logic r;
    } perm_t;
endpackage

// File: rtl/tlb_tag_match.sv
// Parallel tag comparator: flags every valid entry whose tag equals the key.
// Assumes the caller keeps tags unique among valid entries.
module tlb_tag_match #(
    parameter int N     = 8,
    parameter int VPN_W = 20
) (
    input  logic [N-1:0]            valid,
    input  logic [N-1:0][VPN_W-1:0] tags,
    input  logic [VPN_W-1:0]        key,
    output logic [N-1:0]            match
);
    for (genvar g = 0; g < N; g++) begin : g_cmp
        // One comparator per entry.
        assign match[g] = valid[g] && (tags[g] == key);
    end
endmodule

// File: rtl/tlb_first_set.sv
// Priority encoder: index of the lowest set request bit.
// Assumes IDX_W is wide enough to hold N-1.
module tlb_first_set #(
    parameter int N     = 8,
    parameter int IDX_W = 3
) (
    input  logic [N-1:0]     req,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    // Scan downward so the lowest set bit wins.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/tlb_perm_check.sv
// Access-kind permission test for a matched entry.
// Assumes the reserved kind code behaves like a load.
module tlb_perm_check (
    input  tlb_pkg::perm_t perm,
    input  logic [1:0]     kind,
    output logic           allow
);
    // Decode which flags the access kind needs.
    always_comb begin
        case (tlb_pkg::acc_e'(kind))
            tlb_pkg::ACC_FETCH: allow = perm.r && perm.x;
            tlb_pkg::ACC_STORE: allow = perm.w;
            default:            allow = perm.r;
        endcase
    end
endmodule

// File: rtl/tlb_mru.sv
// Fully associative translation buffer with one recency bit per entry.
// Lookup results are registered one cycle after the request; fill and flush
// update state at the next edge. Assumes at most one of lk_valid, fill_valid
// and flush_valid is high per cycle, and N >= 2.
module tlb_mru #(
    parameter int N         = 8,
    parameter int VA_W      = 32,
    parameter int PA_W      = 32,
    parameter int PAGE_BITS = 12,
    parameter int CNT_W     = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  lk_valid,
    input  logic [VA_W-1:0]       lk_vaddr,
    input  logic [1:0]            lk_kind,
    input  logic                  fill_valid,
    input  logic [VA_W-PAGE_BITS-1:0] fill_vpn,
    input  logic [PA_W-PAGE_BITS-1:0] fill_pfn,
    input  logic [2:0]            fill_perm,
    input  logic                  flush_valid,
    input  logic [VA_W-PAGE_BITS-1:0] flush_vpn,
    output logic                  res_valid,
    output logic [1:0]            res_status,
    output logic [PA_W-1:0]       res_paddr,
    output logic [CNT_W-1:0]      cnt_hit,
    output logic [CNT_W-1:0]      cnt_miss,
    output logic [CNT_W-1:0]      cnt_evict
);
    localparam int VPN_W = VA_W - PAGE_BITS;
    localparam int PFN_W = PA_W - PAGE_BITS;
    localparam int IDX_W = $clog2(N);
    localparam int OCC_W = $clog2(N + 1);

    logic [N-1:0]            v_q, v_d, mru_q, mru_d;
    logic [N-1:0][VPN_W-1:0] tag_q;
    logic [N-1:0][PFN_W-1:0] pfn_q;
    tlb_pkg::perm_t [N-1:0]  perm_q;

    logic [VPN_W-1:0] lk_vpn, mt_key;
    logic [N-1:0]     lk_hit_vec, mt_hit_vec;
    logic             lk_found, mt_found, free_found, vict_found, lk_allow;
    logic [IDX_W-1:0] lk_idx, mt_idx, free_idx, vict_idx, wr_idx;
    logic             wr_en, evict;
    logic [OCC_W-1:0] occ;
    logic             all_full, one_free;
    logic [CNT_W-1:0] cnt_sum;

    assign lk_vpn   = lk_vaddr[VA_W-1:PAGE_BITS];
    assign mt_key   = flush_valid ? flush_vpn : fill_vpn;
    assign all_full = &v_q;
    assign cnt_sum  = cnt_hit + cnt_miss;

    tlb_tag_match #(.N(N), .VPN_W(VPN_W)) u_lk_match (
        .valid(v_q), .tags(tag_q), .key(lk_vpn), .match(lk_hit_vec));
    tlb_tag_match #(.N(N), .VPN_W(VPN_W)) u_mt_match (
        .valid(v_q), .tags(tag_q), .key(mt_key), .match(mt_hit_vec));

    tlb_first_set #(.N(N), .IDX_W(IDX_W)) u_lk_enc (
        .req(lk_hit_vec), .found(lk_found), .idx(lk_idx));
    tlb_first_set #(.N(N), .IDX_W(IDX_W)) u_mt_enc (
        .req(mt_hit_vec), .found(mt_found), .idx(mt_idx));
    tlb_first_set #(.N(N), .IDX_W(IDX_W)) u_free_enc (
        .req(~v_q), .found(free_found), .idx(free_idx));
    tlb_first_set #(.N(N), .IDX_W(IDX_W)) u_vict_enc (
        .req(v_q & ~mru_q), .found(vict_found), .idx(vict_idx));

    tlb_perm_check u_perm (
        .perm(perm_q[lk_idx]), .kind(lk_kind), .allow(lk_allow));

    // Count occupied entries to spot the last free slot.
    always_comb begin
        occ = '0;
        for (int i = 0; i < N; i++) occ = occ + OCC_W'(v_q[i]);
        one_free = (occ == OCC_W'(N - 1));
    end

    // Next valid/recency state and the write slot for a fill.
    always_comb begin
        v_d    = v_q;
        mru_d  = mru_q;
        wr_en  = 1'b0;
        wr_idx = '0;
        evict  = 1'b0;
        if (flush_valid) begin
            if (mt_found) begin
                v_d[mt_idx]   = 1'b0;
                mru_d[mt_idx] = 1'b0;
            end
        end else if (fill_valid) begin
            wr_en = 1'b1;
            if (mt_found) begin
                wr_idx = mt_idx;
            end else if (all_full) begin
                wr_idx        = vict_found ? vict_idx : '0;
                evict         = 1'b1;
                v_d[wr_idx]   = 1'b1;
                mru_d[wr_idx] = 1'b0;
            end else begin
                if (one_free) mru_d = '0;
                wr_idx        = free_found ? free_idx : '0;
                v_d[wr_idx]   = 1'b1;
                mru_d[wr_idx] = 1'b0;
            end
        end else if (lk_valid && lk_found) begin
            if (all_full) mru_d = '0;
            mru_d[lk_idx] = 1'b1;
        end
    end

    // Valid and recency bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_q   <= '0;
            mru_q <= '0;
        end else begin
            v_q   <= v_d;
            mru_q <= mru_d;
        end
    end

    // Entry payload, written on fill; guarded by the valid bits.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx]  <= fill_vpn;
            pfn_q[wr_idx]  <= fill_pfn;
            perm_q[wr_idx] <= tlb_pkg::perm_t'(fill_perm);
        end
    end

    // Registered lookup result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid  <= 1'b0;
            res_status <= tlb_pkg::RES_MISS;
            res_paddr  <= '0;
        end else begin
            res_valid  <= lk_valid;
            res_status <= tlb_pkg::RES_MISS;
            res_paddr  <= '0;
            if (lk_valid && lk_found) begin
                if (lk_allow) begin
                    res_status <= tlb_pkg::RES_HIT;
                    res_paddr  <= {pfn_q[lk_idx], lk_vaddr[PAGE_BITS-1:0]};
                end else begin
                    res_status <= tlb_pkg::RES_FAULT;
                end
            end
        end
    end

    // Activity counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_hit   <= '0;
            cnt_miss  <= '0;
            cnt_evict <= '0;
        end else begin
            if (lk_valid && lk_found)  cnt_hit  <= cnt_hit + 1'b1;
            if (lk_valid && !lk_found) cnt_miss <= cnt_miss + 1'b1;
            if (evict)                 cnt_evict <= cnt_evict + 1'b1;
        end
    end

    AST_RES_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> res_valid); // R1
    AST_NOHIT_ZERO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_status != 2'd1) |-> res_paddr == '0); // R3
    AST_FULL_ONE_RECENT: assert property (@(posedge clk) disable iff (!rst_n)
        (&v_q) |-> $countones(mru_q) <= 1); // R4
    AST_EVICT_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_evict != $past(cnt_evict)) |-> $past(fill_valid && (&v_q))); // R6
    AST_UNIQUE_TAG: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_hit_vec)); // R7
    AST_ONE_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> cnt_sum == CNT_W'($past(cnt_sum) + 1'b1)); // R9
endmodule

// File: tb/test_tlb_mru.sv
module test_tlb_mru;
    localparam int N  = 8;
    localparam int VW = 20;
    localparam int PW = 20;
    localparam int CW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lk_valid = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic [1:0] lk_kind = '0;
    logic fill_valid = 1'b0;
    logic [VW-1:0] fill_vpn = '0;
    logic [PW-1:0] fill_pfn = '0;
    logic [2:0] fill_perm = '0;
    logic flush_valid = 1'b0;
    logic [VW-1:0] flush_vpn = '0;
    logic res_valid;
    logic [1:0] res_status;
    logic [31:0] res_paddr;
    logic [CW-1:0] cnt_hit, cnt_miss, cnt_evict;

    tlb_mru i_tlb_mru (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_kind(lk_kind),
        .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn),
        .fill_perm(fill_perm), .flush_valid(flush_valid), .flush_vpn(flush_vpn),
        .res_valid(res_valid), .res_status(res_status), .res_paddr(res_paddr),
        .cnt_hit(cnt_hit), .cnt_miss(cnt_miss), .cnt_evict(cnt_evict));

    always #10 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;

    // Behavioural model built from the requirements.
    bit          m_v[N];
    bit          m_mru[N];
    logic [VW-1:0] m_tag[N];
    logic [PW-1:0] m_pfn[N];
    logic [2:0]  m_perm[N];
    int e_hit, e_miss, e_evict;

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < N; i++) begin m_v[i] = 0; m_mru[i] = 0; end
        e_hit = 0; e_miss = 0; e_evict = 0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
        model_reset();
        chk("R10", "res_valid", 64'(res_valid), 0);
        chk("R10", "cnt_hit", 64'(cnt_hit), 0);
        chk("R10", "cnt_miss", 64'(cnt_miss), 0);
        chk("R10", "cnt_evict", 64'(cnt_evict), 0);
    endtask

    task automatic lookup(logic [VW-1:0] vpn, logic [11:0] off, int kind, string req);
        int idx = -1;
        bit full = 1;
        bit ok;
        logic [1:0] es = 2'd0;
        logic [31:0] ea = '0;
        for (int i = 0; i < N; i++) begin
            if (m_v[i] && m_tag[i] == vpn) idx = i;
            if (!m_v[i]) full = 0;
        end
        if (idx >= 0) begin
            case (kind)
                0: ok = m_perm[idx][0] && m_perm[idx][2];
                2: ok = m_perm[idx][1];
                default: ok = m_perm[idx][0];
            endcase
            if (ok) begin es = 2'd1; ea = {m_pfn[idx], off}; end
            else es = 2'd2;
            if (full) for (int i = 0; i < N; i++) m_mru[i] = 0;
            m_mru[idx] = 1;
            e_hit++;
        end else e_miss++;
        @(negedge clk);
        lk_valid = 1'b1; lk_vaddr = {vpn, off}; lk_kind = 2'(kind);
        @(negedge clk);
        lk_valid = 1'b0;
        chk("R1", "res_valid", 64'(res_valid), 1);
        chk(req, "res_status", 64'(res_status), 64'(es));
        chk("R2", "res_paddr", 64'(res_paddr), 64'(ea));
        chk("R9", "cnt_hit", 64'(cnt_hit), 64'(CW'(e_hit)));
        chk("R9", "cnt_miss", 64'(cnt_miss), 64'(CW'(e_miss)));
    endtask

    task automatic fill(logic [VW-1:0] vpn, logic [PW-1:0] pfn, logic [2:0] perm);
        int idx = -1;
        int occ = 0;
        int slot = -1;
        string req = "R5";
        for (int i = 0; i < N; i++) begin
            if (m_v[i] && m_tag[i] == vpn) idx = i;
            if (m_v[i]) occ++;
        end
        if (idx >= 0) begin
            req = "R7";
            m_pfn[idx] = pfn; m_perm[idx] = perm;
        end else begin
            if (occ == N) begin
                req = "R6";
                for (int i = N - 1; i >= 0; i--) if (!m_mru[i]) slot = i;
                if (slot < 0) slot = 0;
                e_evict++;
            end else begin
                if (occ == N - 1) for (int i = 0; i < N; i++) m_mru[i] = 0;
                for (int i = N - 1; i >= 0; i--) if (!m_v[i]) slot = i;
            end
            m_v[slot] = 1; m_mru[slot] = 0; m_tag[slot] = vpn;
            m_pfn[slot] = pfn; m_perm[slot] = perm;
        end
        @(negedge clk);
        fill_valid = 1'b1; fill_vpn = vpn; fill_pfn = pfn; fill_perm = perm;
        @(negedge clk);
        fill_valid = 1'b0;
        chk("R1", "res_valid idle", 64'(res_valid), 0);
        chk(req, "cnt_evict", 64'(cnt_evict), 64'(CW'(e_evict)));
        chk("R9", "cnt_hit on fill", 64'(cnt_hit), 64'(CW'(e_hit)));
    endtask

    task automatic flush(logic [VW-1:0] vpn);
        for (int i = 0; i < N; i++)
            if (m_v[i] && m_tag[i] == vpn) begin m_v[i] = 0; m_mru[i] = 0; end
        @(negedge clk);
        flush_valid = 1'b1; flush_vpn = vpn;
        @(negedge clk);
        flush_valid = 1'b0;
        chk("R8", "cnt_evict on flush", 64'(cnt_evict), 64'(CW'(e_evict)));
        chk("R9", "cnt_miss on flush", 64'(cnt_miss), 64'(CW'(e_miss)));
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(200000 * 20);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int seed;
        model_reset();
        do_reset();
        lookup(20'h00055, 12'h123, 1, "R10");

        // Every flag combination against every access kind.
        for (int i = 0; i < N; i++) fill(20'h10 + 20'(i), 20'hA0 + 20'(i * 5), 3'(i));
        for (int i = 0; i < N; i++)
            for (int k = 0; k < 4; k++)
                lookup(20'h10 + 20'(i), 12'(i * 273 + k), k, "R3");
        // Evictions with a full buffer, then see who survived.
        for (int i = 0; i < 4; i++) fill(20'h40 + 20'(i), 20'h3C0 + 20'(i), 3'b111);
        for (int i = 0; i < N; i++) lookup(20'h10 + 20'(i), 12'hABC, 1, "R6");

        // Recency sequence on a freshly reset buffer.
        do_reset();
        for (int i = 1; i <= 7; i++) fill(20'(i), 20'(i + 100), 3'b011);
        lookup(20'd1, 12'h001, 1, "R4");
        lookup(20'd2, 12'h002, 2, "R4");
        fill(20'd8, 20'd108, 3'b001);
        lookup(20'd3, 12'h003, 1, "R5");
        fill(20'd20, 20'd120, 3'b111);
        lookup(20'd1, 12'h004, 1, "R6");
        lookup(20'd2, 12'h005, 0, "R4");
        fill(20'd21, 20'd121, 3'b111);
        for (int i = 1; i <= 8; i++) lookup(20'(i), 12'hFFF, 1, "R4");
        lookup(20'd20, 12'h000, 1, "R6");
        lookup(20'd21, 12'h000, 1, "R6");

        // Flush present and absent; overwrite in place.
        flush(20'd5);
        flush(20'd999);
        for (int i = 1; i <= 8; i++) lookup(20'(i), 12'h777, 1, "R8");
        fill(20'd3, 20'd333, 3'b010);
        lookup(20'd3, 12'h010, 2, "R7");
        lookup(20'd3, 12'h011, 1, "R7");

        // Long mixed stream over a small page space.
        seed = 12345;
        for (int n = 0; n < 1500; n++) begin
            int op;
            logic [VW-1:0] pg;
            seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
            op = (seed >> 8) % 10;
            pg = 20'((seed >> 12) % 12);
            if (op < 5) lookup(pg, 12'(seed >> 3), (seed >> 20) % 4, "R4");
            else if (op < 8) fill(pg, 20'((seed >> 5) & 20'hFFFFF), 3'((seed >> 17) & 7));
            else flush(pg);
        end
        finish_run();
    end
endmodule